// File: doc/BRIEF.md
# Pulse-Width Modulator with Queued Duty Samples

This block drives one pulse-width modulated output from a free-running up-counter. Software programs a period and a compare value over a small word-wide register bus. Compare values are pushed into a four-deep queue. The compare register that is actually in use is reloaded from the head of that queue only when the counter wraps to zero, so a period is never cut short or stretched by a write that arrives part-way through it.

The output is high from the start of each period for as long as the count is below the active compare value. It then goes low until the period ends. Because the level comes from a magnitude comparison against a value that is frozen for the whole period, writing a smaller duty value while the counter is already past it cannot cause a period with no falling edge. A programmable divider sits in front of the counter. A self-clearing soft reset returns every register and the queue to zero.

The bus has five registers:

- Control at offset 0x00.
- Status at offset 0x04.
- Sample at offset 0x0C.
- Period at offset 0x10.
- Live count at offset 0x14.

A write is taken on the clock edge on which `reg_wr` is high. Reads are combinational from `reg_addr`.

Top module: `pwm_qduty`

## Requirements
- R1: After reset, every register reads zero, unmapped offsets read zero, and `pwm_out` is low.
- R2: Control register fields:
  - Bit 0 is the run enable.
  - Bit 3 is the soft-reset request.
  - Bits 15:4 hold the divider value.
  - Bit 25 is a stop-enable flag.
  - Bits 27:26 are a two-bit watermark.
  - Every field except bit 3 reads back as written.
- R3: Duty samples written to offset 0x0C enter a four-entry queue. Status bits 2:0 give the number of occupied entries. Entries leave in write order, one at each counter wrap.
- R4: A sample written while the queue holds four entries is discarded and sets status bit 4. Bit 4 stays set until a write to status with bit 4 at 1 clears it; writing 0 there leaves it set.
- R5: The active compare value, read at offset 0x0C, changes only at a counter wrap. A sample written while the queue is empty waits for the next wrap.
- R6: With period P and active sample S, each period is high for min(S,P) counter steps and low for the rest. S=0 gives a constant low output, and S>=P gives a constant high output.
- R7: With divider value N, the counter advances once every N+1 clocks. It counts 0 to P-1 and then wraps to 0. Offset 0x14 reads the live count.
- R8: Writing a sample below the current count part-way through a period does not suppress the falling edge of that period.
- R9: Any write to the period register restarts the counter and the divider from zero.
- R10: With the enable bit clear, `pwm_out` is low, the counter holds at zero, and queued samples are kept.
- R11: Writing 1 to control bit 3 makes that bit read 1 for one cycle. On the next edge every register, the queue, the counter and the active compare value are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench builds the block with an 8-bit counter and the four-entry queue. With that configuration it can sweep, for every divider value from 0 to 2 and every period from 1 to 6, each sample value from 0 to one above the period. Each case counts the high clocks over a whole period and compares the total against the arithmetic expectation. The short periods put queue order, overflow, mid-period duty drops and the soft reset within a few dozen clocks each.

// File: rtl/pwm_qduty_pkg.sv
package pwm_qduty_pkg;
  localparam int ADDR_W = 5;
  localparam int BUS_W  = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_SAMPLE = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_PERIOD = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 5'h14;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SRST_BIT = 3;
  localparam int PRE_LSB       = 4;
  localparam int PRE_W         = 12;
  localparam int CTRL_STOP_BIT = 25;
  localparam int WM_LSB        = 26;
  localparam int WM_W          = 2;
  localparam int STAT_OVF_BIT  = 4;

  typedef struct packed {
    logic [WM_W-1:0]  wmark;
    logic             stop_en;
    logic [PRE_W-1:0] prescale;
    logic             enable;
  } ctrl_t;
endpackage

// File: rtl/pwm_qduty_prescale.sv
module pwm_qduty_prescale #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pre_q, pre_d;

  // >= rather than == so that a smaller divider written mid-count still wraps
  assign tick = !clr && (pre_q >= div);

  always_comb begin
    pre_d = pre_q + 1'b1;
    if (clr || tick) pre_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  a_r7_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_q == '0));
endmodule

// File: rtl/pwm_qduty_fifo.sv
module pwm_qduty_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       empty,
  output logic                       full,
  output logic                       ovf_evt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d, wr_ptr_q, wr_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;
  logic [W-1:0]     slots [DEPTH];

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign ovf_evt = push && full && !flush;
  assign count   = cnt_q;
  assign head    = slots[rd_ptr_q];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] slot_q;
    logic         slot_we;
    assign slot_we  = do_push && (wr_ptr_q == PTR_W'(i));
    assign slots[i] = slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_we) slot_q <= push_data;
    end
  end

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      rd_ptr_d = '0;
      wr_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_push) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (cnt_q == CNT_W'(DEPTH)));
  a_r11_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_qduty_timebase.sv
module pwm_qduty_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             rollover
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic             step, at_end;

  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign at_end   = (cnt_inc >= {1'b0, period});
  assign step     = run && !restart && tick;
  assign rollover = step && at_end;
  assign cnt      = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || restart) cnt_d = '0;
    else if (step)       cnt_d = at_end ? '0 : cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
  a_r7_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    (period != '0) |-> (cnt_q < period));
  a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_qduty.sv
module pwm_qduty
  import pwm_qduty_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              pwm_out
);
  localparam int FCNT_W = $clog2(FIFO_DEPTH+1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic wr_ctrl, wr_stat, wr_sample, wr_period;
  assign wr_ctrl   = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_stat   = reg_wr && (reg_addr == OFS_STAT);
  assign wr_sample = reg_wr && (reg_addr == OFS_SAMPLE);
  assign wr_period = reg_wr && (reg_addr == OFS_PERIOD);

  ctrl_t            ctrl_q, ctrl_d;
  logic             srst_q, srst_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W-1:0] active_q, active_d;
  logic             ovf_q, ovf_d;
  logic             active_en;

  logic              tick, rollover, restart;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  fifo_head;
  logic [FCNT_W-1:0] fifo_count;
  logic              fifo_empty, fifo_full, fifo_ovf;

  assign restart = wr_period || srst_q;

  pwm_qduty_prescale #(.DIV_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_i_n),
    .clr  (!ctrl_q.enable || restart),
    .div  (ctrl_q.prescale),
    .tick (tick)
  );

  pwm_qduty_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .run     (ctrl_q.enable),
    .restart (restart),
    .tick    (tick),
    .period  (period_q),
    .cnt     (cnt),
    .rollover(rollover)
  );

  pwm_qduty_fifo #(.W(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .flush    (srst_q),
    .push     (wr_sample && !srst_q),
    .push_data(reg_wdata[CNT_W-1:0]),
    .pop      (rollover),
    .head     (fifo_head),
    .count    (fifo_count),
    .empty    (fifo_empty),
    .full     (fifo_full),
    .ovf_evt  (fifo_ovf)
  );

  // next-state for the register file
  always_comb begin
    ctrl_d    = ctrl_q;
    period_d  = period_q;
    ovf_d     = ovf_q;
    active_d  = active_q;
    srst_d    = 1'b0;
    active_en = 1'b0;
    if (srst_q) begin
      ctrl_d    = '0;
      period_d  = '0;
      ovf_d     = 1'b0;
      active_d  = '0;
      active_en = 1'b1;
    end else begin
      if (wr_ctrl) begin
        ctrl_d.enable   = reg_wdata[CTRL_EN_BIT];
        ctrl_d.prescale = reg_wdata[PRE_LSB +: PRE_W];
        ctrl_d.stop_en  = reg_wdata[CTRL_STOP_BIT];
        ctrl_d.wmark    = reg_wdata[WM_LSB +: WM_W];
        srst_d          = reg_wdata[CTRL_SRST_BIT];
      end
      if (wr_period) period_d = reg_wdata[CNT_W-1:0];
      if (wr_stat && reg_wdata[STAT_OVF_BIT]) ovf_d = 1'b0;
      if (fifo_ovf) ovf_d = 1'b1;
      if (rollover && !fifo_empty) begin
        active_d  = fifo_head;
        active_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q   <= '0;
      srst_q   <= 1'b0;
      period_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      srst_q   <= srst_d;
      period_q <= period_d;
      ovf_q    <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)       active_q <= '0;
    else if (active_en) active_q <= active_d;
  end

  // magnitude compare against a value frozen for the whole period
  assign pwm_out = ctrl_q.enable && (cnt < active_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[CTRL_EN_BIT]          = ctrl_q.enable;
        reg_rdata[CTRL_SRST_BIT]        = srst_q;
        reg_rdata[PRE_LSB +: PRE_W]     = ctrl_q.prescale;
        reg_rdata[CTRL_STOP_BIT]        = ctrl_q.stop_en;
        reg_rdata[WM_LSB +: WM_W]       = ctrl_q.wmark;
      end
      OFS_STAT: begin
        reg_rdata[FCNT_W-1:0]           = fifo_count;
        reg_rdata[STAT_OVF_BIT]         = ovf_q;
      end
      OFS_SAMPLE: reg_rdata[CNT_W-1:0]  = active_q;
      OFS_PERIOD: reg_rdata[CNT_W-1:0]  = period_q;
      OFS_COUNT:  reg_rdata[CNT_W-1:0]  = cnt;
      default:    reg_rdata             = '0;
    endcase
  end

  a_r5_active_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!rollover && !srst_q) |=> $stable(active_q));
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ovf_q && !srst_q && !(wr_stat && reg_wdata[STAT_OVF_BIT])) |=> ovf_q);
  a_r11_srst_clears: assert property (@(posedge clk) disable iff (!rst_i_n)
    srst_q |=> (!ctrl_q.enable && period_q == '0 && !ovf_q && active_q == '0 && !srst_q));
  a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!ctrl_q.enable) |-> !pwm_out);
endmodule

// File: tb/tb_pwm_qduty.sv
`timescale 1ns/1ps
module tb_pwm_qduty;
  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_SMP = 5'h0C,
                         A_PER = 5'h10, A_CNT = 5'h14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        pwm_out;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pwm_qduty #(.CNT_W(8), .FIFO_DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int d);
    reg_addr = a;
    #0.5;
    d = int'(reg_rdata);
  endtask

  task automatic wait_cnt(input int v);
    int c;
    for (int i = 0; i < 2000; i++) begin
      rd(A_CNT, c);
      if (c == v) break;
      @(negedge clk);
    end
  endtask

  task automatic soft_reset();
    wr(A_CTRL, 32'h8);
    @(negedge clk);
  endtask

  initial begin
    int v;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_SMP, v);  chk("R1 sample", v, 0);
    rd(A_PER, v);  chk("R1 period", v, 0);
    rd(A_CNT, v);  chk("R1 count", v, 0);
    rd(5'h08, v);  chk("R1 unmapped", v, 0);
    chk("R1 out", int'(pwm_out), 0);

    // R2: field readback
    wr(A_CTRL, (32'd2 << 26) | (32'd1 << 25) | (32'hABC << 4));
    rd(A_CTRL, v); chk("R2 ctrl fields", v, int'((32'd2 << 26) | (32'd1 << 25) | (32'hABC << 4)));
    wr(A_CTRL, 32'h0);

    // R6 / R7: sweep divider, period, sample; count high clocks over one period
    for (int n = 0; n <= 2; n++) begin
      for (int p = 1; p <= 6; p++) begin
        for (int s = 0; s <= p + 1; s++) begin
          int len, hi, exp_hi;
          len = p * (n + 1);
          wr(A_CTRL, 32'h0);
          wr(A_PER, 32'(p));
          wr(A_SMP, 32'(s));
          wr(A_CTRL, (32'(n) << 4) | 32'h1);
          repeat (len) @(negedge clk);
          hi = 0;
          for (int k = 0; k < len; k++) begin
            hi += int'(pwm_out);
            @(negedge clk);
          end
          exp_hi = ((s < p) ? s : p) * (n + 1);
          chk($sformatf("R6 high clocks n=%0d p=%0d s=%0d", n, p, s), hi, exp_hi);
        end
      end
    end

    // R7: live count with divider 2, period 5
    soft_reset();
    wr(A_PER, 32'd5);
    wr(A_CTRL, (32'd2 << 4) | 32'h1);
    for (int m = 0; m < 30; m++) begin
      rd(A_CNT, v);
      chk($sformatf("R7 count m=%0d", m), v, (m / 3) % 5);
      @(negedge clk);
    end

    // R4 / R3: overflow and queue order
    soft_reset();
    wr(A_PER, 32'd4);
    wr(A_SMP, 32'd10); wr(A_SMP, 32'd20); wr(A_SMP, 32'd30); wr(A_SMP, 32'd40);
    wr(A_SMP, 32'd50);
    rd(A_STAT, v); chk("R4 full with overflow bit", v, 32'h14);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R4 write 0 keeps overflow", v, 32'h14);
    wr(A_STAT, 32'h10);
    rd(A_STAT, v); chk("R4 w1c clears overflow", v, 32'h4);
    wr(A_CTRL, 32'h1);
    for (int e = 0; e < 5; e++) begin
      repeat (4) @(negedge clk);
      rd(A_SMP, v);  chk($sformatf("R3 order step %0d", e), v, (e < 4) ? 10 * (e + 1) : 40);
      rd(A_STAT, v); chk($sformatf("R3 count step %0d", e), v, (e < 4) ? 3 - e : 0);
    end

    // R5 / R8: lower the duty below the running count
    soft_reset();
    wr(A_PER, 32'd8);
    wr(A_SMP, 32'd6);
    wr(A_CTRL, 32'h1);
    repeat (8) @(negedge clk);
    rd(A_SMP, v); chk("R5 loaded at wrap", v, 6);
    wait_cnt(4);
    wr(A_SMP, 32'd2);
    rd(A_SMP, v);  chk("R5 held until wrap", v, 6);
    rd(A_STAT, v); chk("R5 queued one", v, 1);
    wait_cnt(6); chk("R8 falls at cnt 6", int'(pwm_out), 0);
    wait_cnt(7); chk("R8 low at cnt 7", int'(pwm_out), 0);
    wait_cnt(0);
    rd(A_SMP, v); chk("R5 new value after wrap", v, 2);
    chk("R6 high at cnt 0", int'(pwm_out), 1);
    wait_cnt(2); chk("R6 low at cnt 2", int'(pwm_out), 0);

    // R9: period write restarts
    soft_reset();
    wr(A_PER, 32'd100);
    wr(A_CTRL, 32'h1);
    repeat (10) @(negedge clk);
    rd(A_CNT, v); chk("R9 running", v, 10);
    wr(A_PER, 32'd100);
    rd(A_CNT, v); chk("R9 restarted", v, 0);

    // R10: disable keeps queue, forces low
    soft_reset();
    wr(A_PER, 32'd4);
    wr(A_SMP, 32'd9);
    wr(A_CTRL, 32'h1);
    repeat (4) @(negedge clk);
    wr(A_PER, 32'd200);
    wr(A_SMP, 32'd3);
    wr(A_SMP, 32'd4);
    rd(A_STAT, v); chk("R10 two queued", v, 2);
    chk("R10 high while running", int'(pwm_out), 1);
    wr(A_CTRL, 32'h0);
    chk("R10 low when disabled", int'(pwm_out), 0);
    repeat (5) @(negedge clk);
    rd(A_CNT, v);  chk("R10 count held", v, 0);
    rd(A_STAT, v); chk("R10 queue kept", v, 2);

    // R11: soft reset
    wr(A_PER, 32'd50);
    wr(A_SMP, 32'd5);
    wr(A_STAT, 32'h0);
    wr(A_CTRL, (32'd1 << 26) | (32'd3 << 4) | 32'h1 | 32'h8);
    rd(A_CTRL, v); chk("R11 bit visible one cycle", v, int'((32'd1 << 26) | (32'd3 << 4) | 32'h9));
    @(negedge clk);
    rd(A_CTRL, v); chk("R11 ctrl cleared", v, 0);
    rd(A_STAT, v); chk("R11 status cleared", v, 0);
    rd(A_PER, v);  chk("R11 period cleared", v, 0);
    rd(A_SMP, v);  chk("R11 sample cleared", v, 0);
    rd(A_CNT, v);  chk("R11 count cleared", v, 0);
    chk("R11 out low", int'(pwm_out), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule